// File: doc/BRIEF.md
# Road-Window Hit Filter

This block takes the stream of finished cluster centroids for one detector channel and turns the axial ones into track hits. At the start of each event, up to 46 road windows arrive one after another, each as an inclusive lower and upper bound on the integer strip position. The slot a window lands in is its track number. Each axial centroid is then tested against every loaded window at once. For every window that contains the centroid, the block writes one 32-bit hit word, in ascending track order. Z-axis centroids are not compared. They leave at once as a formatted 32-bit word. At end of event, a trailer word carrying the event number and the error flags closes the stream.

The comparison yields a hit vector, which is masked by the number of windows loaded since the last event start. It is then scanned by a single pointer. The pointer starts in the first group of ten tracks that holds a hit, skips any group that holds no hit and stops at the last loaded window. No input is taken while a scan is running. The output is a valid-qualified word stream with no backpressure.

Top module: `road_hit_filter`

## Requirements
- R1: Each `road_wr` pulse stores (`road_lo`, `road_hi`) in the next free slot, counted from slot 0 after `evt_start`; the slot index is the track number reported in hits.
- R2: Writes beyond 46 loaded windows are ignored. `evt_start` resets the loaded count to zero, and a `road_wr` in the same cycle as `evt_start` is dropped.
- R3: An axial centroid hits a window when lo <= `cent_value[12:2]` <= hi, with both bounds inclusive; the two fraction bits `cent_value[1:0]` take no part.
- R4: Slots not written since the last `evt_start` never produce a hit, even when they still hold a window from an earlier event that would contain the centroid.
- R5: For each hit, one word is emitted as {track[5:0], pulse[1:0], seq[7:0], hdi[2:0], centroid[12:0]}, MSB first. Hits for one centroid come out in ascending track order.
- R6: A z-axis centroid (`cent_axial`=0) accepted in a cycle yields, on the next cycle, one word {1'b0, smt[2:0], dtype[1:0], pulse[1:0], seq[7:0], hdi[2:0], centroid[12:0]} and no hit words.
- R7: An accepted end of event yields, on the next cycle, the trailer {5'b11110, serr, mm, 3'b000, smt[2:0], seq[7:0], hdi[2:0], event[7:0]}.
- R8: `in_ready` drops on the cycle after an axial centroid with at least one hit is accepted and stays low until its last hit word is written. An axial centroid with no hit leaves `in_ready` high. When a centroid and an end of event are both offered, the centroid is taken first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_start | input | 1 | Event start; clears the loaded window count |
| road_wr | input | 1 | Road window write strobe |
| road_lo | input | 11 | Window lower bound (inclusive) |
| road_hi | input | 11 | Window upper bound (inclusive) |
| cent_valid | input | 1 | Centroid offered |
| cent_axial | input | 1 | 1 = axial centroid, 0 = z-axis centroid |
| cent_value | input | 13 | Centroid, 11 integer bits and 2 fraction bits |
| cent_pulse | input | 2 | Pulse area class |
| cent_dtype | input | 2 | Data type of the centroid |
| in_ready | output | 1 | Centroid or end of event accepted this cycle when offered |
| eoe_valid | input | 1 | End of event offered |
| eoe_serr | input | 1 | Read error flag for the trailer |
| eoe_mm | input | 1 | Identifier mismatch flag for the trailer |
| eoe_event | input | 8 | Event number for the trailer |
| cfg_seq_id | input | 8 | Channel sequencer identifier |
| cfg_hdi_id | input | 3 | Channel interconnect identifier |
| cfg_smt_id | input | 3 | Stream identifier |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Hit, z-axis or trailer word |

## Verification
The bench places a centroid exactly on a lower bound and another exactly on an upper bound, both with nonzero fraction bits. An off-by-one or fraction-sensitive compare would lose one of those hits or add a wrong one. One centroid hits tracks 9 and 10, which sit on opposite sides of a group edge, and another hits only track 45, in the last and short group. A faulty skip-ahead would drop the hit after the edge or run past the last loaded window. A second event loads only five windows over stale windows that still contain the centroid, so a mask built from anything other than the fresh count shows up as extra tracks. A 47th write, a write in the same cycle as event start, and a centroid offered together with an end of event catch slot overwrites and priority mistakes.

// File: rtl/rhf_pkg.sv
package rhf_pkg;

    localparam int ROAD_W  = 11;
    localparam int FRAC_W  = 2;
    localparam int CENT_W  = ROAD_W + FRAC_W;
    localparam int TRACK_W = 6;
    localparam int WORD_W  = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic logic [WORD_W-1:0] fmt_hit(
        input logic [TRACK_W-1:0] track,
        input logic [1:0]         pulse,
        input logic [7:0]         seq,
        input logic [2:0]         hdi,
        input logic [CENT_W-1:0]  cent
    );
        return {track, pulse, seq, hdi, cent};
    endfunction

    function automatic logic [WORD_W-1:0] fmt_z(
        input logic [2:0]        smt,
        input logic [1:0]        dtype,
        input logic [1:0]        pulse,
        input logic [7:0]        seq,
        input logic [2:0]        hdi,
        input logic [CENT_W-1:0] cent
    );
        return {1'b0, smt, dtype, pulse, seq, hdi, cent};
    endfunction

    function automatic logic [WORD_W-1:0] fmt_trailer(
        input logic       serr,
        input logic       mm,
        input logic [2:0] smt,
        input logic [7:0] seq,
        input logic [2:0] hdi,
        input logic [7:0] evt
    );
        return {5'b11110, serr, mm, 3'b000, smt, seq, hdi, evt};
    endfunction

endpackage

// File: rtl/rhf_road_bank.sv
module rhf_road_bank
    import rhf_pkg::*;
#(
    parameter int NUM_ROADS = 46,
    parameter int CNT_W     = $clog2(NUM_ROADS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 wr,
    input  logic [ROAD_W-1:0]    wr_lo,
    input  logic [ROAD_W-1:0]    wr_hi,
    input  logic [ROAD_W-1:0]    probe,
    output logic [CNT_W-1:0]     loaded,
    output logic [NUM_ROADS-1:0] hit_vec
);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             take;

    always_comb begin
        take  = wr && !clear && (cnt_q < CNT_W'(NUM_ROADS));
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (take)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    for (genvar i = 0; i < NUM_ROADS; i++) begin : g_cmp
        logic [ROAD_W-1:0] lo_q, hi_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (take && cnt_q == CNT_W'(i)) begin
                lo_q <= wr_lo;
                hi_q <= wr_hi;
            end
        end

        assign hit_vec[i] = (probe >= lo_q) && (probe <= hi_q)
                          && (cnt_q > CNT_W'(i));
    end

    assign loaded = cnt_q;

endmodule

// File: rtl/rhf_group_flags.sv
module rhf_group_flags #(
    parameter int NUM_ROADS  = 46,
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_SZ   = (NUM_ROADS + NUM_GROUPS - 1) / NUM_GROUPS
) (
    input  logic [NUM_ROADS-1:0]  vec,
    output logic [NUM_GROUPS-1:0] flags
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int LO  = g * GROUP_SZ;
        localparam int END = ((LO + GROUP_SZ) > NUM_ROADS) ? NUM_ROADS : (LO + GROUP_SZ);
        assign flags[g] = |vec[END-1:LO];
    end

endmodule

// File: rtl/road_hit_filter.sv
module road_hit_filter
    import rhf_pkg::*;
#(
    parameter int NUM_ROADS  = 46,
    parameter int NUM_GROUPS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_start,
    input  logic              road_wr,
    input  logic [10:0]       road_lo,
    input  logic [10:0]       road_hi,
    input  logic              cent_valid,
    input  logic              cent_axial,
    input  logic [12:0]       cent_value,
    input  logic [1:0]        cent_pulse,
    input  logic [1:0]        cent_dtype,
    output logic              in_ready,
    input  logic              eoe_valid,
    input  logic              eoe_serr,
    input  logic              eoe_mm,
    input  logic [7:0]        eoe_event,
    input  logic [7:0]        cfg_seq_id,
    input  logic [2:0]        cfg_hdi_id,
    input  logic [2:0]        cfg_smt_id,
    output logic              out_valid,
    output logic [31:0]       out_word
);

    localparam int CNT_W    = $clog2(NUM_ROADS + 1);
    localparam int GROUP_SZ = (NUM_ROADS + NUM_GROUPS - 1) / NUM_GROUPS;

    typedef struct packed {
        scan_state_e            st;
        logic [NUM_ROADS-1:0]   hits;
        logic [CNT_W-1:0]       idx;
        logic [CNT_W-1:0]       lim;
        logic [CENT_W-1:0]      cent;
        logic [1:0]             pulse;
        logic                   ovld;
        logic [WORD_W-1:0]      oword;
    } regs_t;

    regs_t r_d, r_q;

    logic [CNT_W-1:0]      road_cnt;
    logic [NUM_ROADS-1:0]  hit_raw;
    logic [NUM_GROUPS-1:0] raw_flags;
    logic [NUM_GROUPS-1:0] scan_flags;
    logic                  scanning;

    rhf_road_bank #(
        .NUM_ROADS (NUM_ROADS),
        .CNT_W     (CNT_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (evt_start),
        .wr      (road_wr),
        .wr_lo   (road_lo),
        .wr_hi   (road_hi),
        .probe   (cent_value[CENT_W-1:FRAC_W]),
        .loaded  (road_cnt),
        .hit_vec (hit_raw)
    );

    rhf_group_flags #(
        .NUM_ROADS  (NUM_ROADS),
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SZ   (GROUP_SZ)
    ) u_raw_flags (
        .vec   (hit_raw),
        .flags (raw_flags)
    );

    rhf_group_flags #(
        .NUM_ROADS  (NUM_ROADS),
        .NUM_GROUPS (NUM_GROUPS),
        .GROUP_SZ   (GROUP_SZ)
    ) u_scan_flags (
        .vec   (r_q.hits),
        .flags (scan_flags)
    );

    logic             any_hit;
    logic [CNT_W-1:0] first_idx;
    logic [CNT_W-1:0] nxt;
    logic             at_edge;
    int               edge_grp;
    logic             found;
    logic [CNT_W-1:0] jump_idx;

    always_comb begin
        r_d       = r_q;
        r_d.ovld  = 1'b0;
        r_d.oword = '0;

        // Start point of a new scan: first group carrying a hit.
        any_hit   = 1'b0;
        first_idx = '0;
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (raw_flags[g]) begin
                any_hit   = 1'b1;
                first_idx = CNT_W'(g * GROUP_SZ);
            end
        end

        // Skip-ahead of a running scan at each group edge.
        nxt      = r_q.idx + 1'b1;
        at_edge  = 1'b0;
        edge_grp = 0;
        for (int g = 1; g < NUM_GROUPS; g++) begin
            if (nxt == CNT_W'(g * GROUP_SZ)) begin
                at_edge  = 1'b1;
                edge_grp = g;
            end
        end
        found    = 1'b0;
        jump_idx = CNT_W'(NUM_ROADS);
        for (int g = NUM_GROUPS - 1; g >= 0; g--) begin
            if (g >= edge_grp && scan_flags[g]) begin
                found    = 1'b1;
                jump_idx = CNT_W'(g * GROUP_SZ);
            end
        end
        if (at_edge)
            nxt = found ? jump_idx : CNT_W'(NUM_ROADS);

        case (r_q.st)
            ST_IDLE: begin
                if (cent_valid) begin
                    if (cent_axial) begin
                        if (any_hit) begin
                            r_d.st    = ST_SCAN;
                            r_d.hits  = hit_raw;
                            r_d.idx   = first_idx;
                            r_d.lim   = road_cnt;
                            r_d.cent  = cent_value;
                            r_d.pulse = cent_pulse;
                        end
                    end else begin
                        r_d.ovld  = 1'b1;
                        r_d.oword = fmt_z(cfg_smt_id, cent_dtype, cent_pulse,
                                          cfg_seq_id, cfg_hdi_id, cent_value);
                    end
                end else if (eoe_valid) begin
                    r_d.ovld  = 1'b1;
                    r_d.oword = fmt_trailer(eoe_serr, eoe_mm, cfg_smt_id,
                                            cfg_seq_id, cfg_hdi_id, eoe_event);
                end
            end
            ST_SCAN: begin
                if (r_q.hits[r_q.idx]) begin
                    r_d.ovld  = 1'b1;
                    r_d.oword = fmt_hit(TRACK_W'(r_q.idx), r_q.pulse,
                                        cfg_seq_id, cfg_hdi_id, r_q.cent);
                end
                r_d.idx = nxt;
                if (nxt >= r_q.lim)
                    r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scanning  = (r_q.st == ST_SCAN);
    assign in_ready  = (r_q.st == ST_IDLE);
    assign out_valid = r_q.ovld;
    assign out_word  = r_q.oword;

endmodule

// File: rtl/rhf_checker.sv
module rhf_checker #(
    parameter int NUM_ROADS = 46,
    parameter int CNT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             cent_valid,
    input logic             cent_axial,
    input logic             eoe_valid,
    input logic             out_valid,
    input logic [31:0]      out_word,
    input logic             scanning,
    input logic [CNT_W-1:0] road_cnt
);

    assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        road_cnt <= CNT_W'(NUM_ROADS));

    assert_track_loaded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(scanning)) |-> (CNT_W'(out_word[31:26]) < road_cnt));

    assert_zword_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && cent_valid && !cent_axial) |=> (out_valid && !out_word[31]));

    assert_trailer_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && eoe_valid && !cent_valid) |=> (out_valid && out_word[31:27] == 5'b11110));

    assert_scan_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scanning) |-> $past(in_ready && cent_valid && cent_axial));

endmodule

bind road_hit_filter rhf_checker #(
    .NUM_ROADS (NUM_ROADS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .cent_valid (cent_valid),
    .cent_axial (cent_axial),
    .eoe_valid  (eoe_valid),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .scanning   (scanning),
    .road_cnt   (road_cnt)
);

// File: tb/road_hit_filter_test.sv
`timescale 1ns/1ps
module road_hit_filter_test;

    localparam int NR = 46;
    localparam logic [7:0] SEQ = 8'hA5;
    localparam logic [2:0] HDI = 3'd6;
    localparam logic [2:0] SMT = 3'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_start = 1'b0, road_wr = 1'b0;
    logic [10:0] road_lo = '0, road_hi = '0;
    logic        cent_valid = 1'b0, cent_axial = 1'b0;
    logic [12:0] cent_value = '0;
    logic [1:0]  cent_pulse = '0, cent_dtype = '0;
    logic        in_ready;
    logic        eoe_valid = 1'b0, eoe_serr = 1'b0, eoe_mm = 1'b0;
    logic [7:0]  eoe_event = '0;
    logic        out_valid;
    logic [31:0] out_word;

    always #5 clk = ~clk;

    road_hit_filter uut (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .road_wr(road_wr),
        .road_lo(road_lo), .road_hi(road_hi), .cent_valid(cent_valid),
        .cent_axial(cent_axial), .cent_value(cent_value), .cent_pulse(cent_pulse),
        .cent_dtype(cent_dtype), .in_ready(in_ready), .eoe_valid(eoe_valid),
        .eoe_serr(eoe_serr), .eoe_mm(eoe_mm), .eoe_event(eoe_event),
        .cfg_seq_id(SEQ), .cfg_hdi_id(HDI), .cfg_smt_id(SMT),
        .out_valid(out_valid), .out_word(out_word)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit mon_on = 0;

    // Reference model state
    int m_lo[NR];
    int m_hi[NR];
    int m_cnt = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Output monitor: compare every valid word against the model queue.
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected word", out_word, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_word == e, t, out_word, e);
            end
        end
    end

    task automatic do_evt_start(input bit with_wr);
        @(negedge clk);
        evt_start = 1'b1;
        road_wr   = with_wr;
        road_lo   = 11'd0;
        road_hi   = 11'd2047;
        @(posedge clk);
        @(negedge clk);
        evt_start = 1'b0;
        road_wr   = 1'b0;
        m_cnt = 0;   // R2: write in the same cycle is dropped
    endtask

    task automatic load(input int lo, input int hi);
        @(negedge clk);
        road_wr = 1'b1;
        road_lo = 11'(lo);
        road_hi = 11'(hi);
        @(posedge clk);
        @(negedge clk);
        road_wr = 1'b0;
        if (m_cnt < NR) begin
            m_lo[m_cnt] = lo;
            m_hi[m_cnt] = hi;
            m_cnt++;
        end
    endtask

    task automatic model_cent(input bit axial, input logic [12:0] v, input logic [1:0] p, input logic [1:0] dt);
        if (axial) begin
            int ip;
            ip = int'(v[12:2]);
            for (int i = 0; i < m_cnt; i++) begin
                if (ip >= m_lo[i] && ip <= m_hi[i]) begin
                    exp_q.push_back({6'(i), p, SEQ, HDI, v});
                    tag_q.push_back($sformatf("R3 R5 hit track %0d cent %0d", i, ip));
                end
            end
        end else begin
            exp_q.push_back({1'b0, SMT, dt, p, SEQ, HDI, v});
            tag_q.push_back("R6 z word");
        end
    endtask

    task automatic wait_ready;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
    endtask

    task automatic send_cent(input bit axial, input logic [12:0] v, input logic [1:0] p, input logic [1:0] dt);
        wait_ready();
        model_cent(axial, v, p, dt);
        cent_valid = 1'b1;
        cent_axial = axial;
        cent_value = v;
        cent_pulse = p;
        cent_dtype = dt;
        @(posedge clk);
        @(negedge clk);
        cent_valid = 1'b0;
    endtask

    task automatic send_eoe(input bit serr, input bit mm, input logic [7:0] ev);
        wait_ready();
        exp_q.push_back({5'b11110, serr, mm, 3'b000, SMT, SEQ, HDI, ev});
        tag_q.push_back("R7 trailer");
        eoe_valid = 1'b1;
        eoe_serr  = serr;
        eoe_mm    = mm;
        eoe_event = ev;
        @(posedge clk);
        @(negedge clk);
        eoe_valid = 1'b0;
    endtask

    task automatic drain;
        for (int k = 0; k < 200; k++) begin
            if (exp_q.size() == 0 && in_ready) break;
            @(negedge clk);
        end
        check(exp_q.size() == 0, "R5 missing words", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "reset out_valid", 32'(out_valid), 32'h0);
        check(in_ready == 1'b1, "R8 reset in_ready", 32'(in_ready), 32'h1);
        mon_on = 1;

        // Event A: full load of 46 windows (R1)
        do_evt_start(1'b0);
        for (int i = 0; i < NR; i++) load(i * 40, i * 40 + 50);
        // 47th write ignored (R2): would cover everything
        load(0, 2047);

        // R3: 45 with fraction bits hits tracks 0 and 1
        send_cent(1'b1, {11'd45, 2'b11}, 2'd1, 2'd0);
        check(in_ready == 1'b0, "R8 busy after hit", 32'(in_ready), 32'h0);
        drain();
        // R3 upper bound exactly: 1850 hits only track 45 (last group)
        send_cent(1'b1, {11'd1850, 2'b01}, 2'd2, 2'd0);
        drain();
        // R3 lower bound / group edge: 400 hits tracks 9 and 10
        send_cent(1'b1, {11'd400, 2'b10}, 2'd3, 2'd0);
        drain();
        // R2 R8: 2000 matches nothing (47th window was dropped)
        send_cent(1'b1, {11'd2000, 2'b00}, 2'd0, 2'd0);
        check(in_ready == 1'b1, "R2 R8 no hit stays ready", 32'(in_ready), 32'h1);
        check(out_valid == 1'b0, "R2 no word for unmatched", 32'(out_valid), 32'h0);
        drain();
        // R6: z centroid bypasses compare, word on next cycle
        send_cent(1'b0, {11'd45, 2'b10}, 2'd2, 2'd1);
        check(out_valid == 1'b1, "R6 z word timing", 32'(out_valid), 32'h1);
        drain();
        // R7 trailer
        send_eoe(1'b1, 1'b0, 8'h3C);
        check(out_valid == 1'b1, "R7 trailer timing", 32'(out_valid), 32'h1);
        drain();

        // R8: centroid and end of event together; centroid first
        wait_ready();
        model_cent(1'b0, {11'd7, 2'b01}, 2'd1, 2'd2);
        exp_q.push_back({5'b11110, 1'b0, 1'b1, 3'b000, SMT, SEQ, HDI, 8'h81});
        tag_q.push_back("R8 trailer after centroid");
        cent_valid = 1'b1; cent_axial = 1'b0; cent_value = {11'd7, 2'b01};
        cent_pulse = 2'd1; cent_dtype = 2'd2;
        eoe_valid = 1'b1; eoe_serr = 1'b0; eoe_mm = 1'b1; eoe_event = 8'h81;
        @(posedge clk);
        @(negedge clk);
        cent_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        eoe_valid = 1'b0;
        drain();

        // Event B: only five windows; stale windows must stay masked (R4)
        do_evt_start(1'b0);
        for (int i = 0; i < 5; i++) load(1000 + i, 1010);
        send_cent(1'b1, {11'd1005, 2'b00}, 2'd1, 2'd0);
        drain();
        send_cent(1'b1, {11'd1800, 2'b00}, 2'd1, 2'd0);
        check(in_ready == 1'b1, "R4 stale window masked", 32'(in_ready), 32'h1);
        drain();

        // R2: write in the same cycle as event start is dropped
        do_evt_start(1'b1);
        load(100, 100);
        send_cent(1'b1, {11'd100, 2'b11}, 2'd3, 2'd0);
        drain();
        send_eoe(1'b0, 1'b1, 8'hFF);
        drain();

        repeat (5) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule